// File: doc/BRIEF.md
# Logic Self-Test Scan Sequencer

This block runs a structural self-test over a group of parallel internal scan chains without any pattern data from outside. After a start pulse it seeds an on-chip pseudo-random generator. The generator output is spread through a small XOR network onto every chain input. The block then repeats a load/capture/unload cycle for a programmed number of patterns. It drives scan-enable and the capture pulses itself, so delay tests need no precise external pin timing.

Two at-speed timings are offered. In the shift-launch timing, the final shift of each load is the launch, and the capture follows in the very next clock. In the double-capture timing, scan-enable is dropped for a settling cycle, and then two capture pulses follow back to back, so that the second captures the circuit's response to the first. Every unloaded response is folded into a multiple-input signature register. Only the final signature matters: at the end it is compared with a programmed expected value, and the block raises done and pass.

The block has no data streams with back-pressure. Every pin is a plain level or pulse sampled on the rising clock edge. The unload of one pattern overlaps the load of the next. An extra shift-only load flushes the last response.

Top module: `lbist_ctrl`

## Requirements
- R1: A start pulse accepted while idle or finished loads the generator with `seed_prpg` and the signature register with `seed_misr`. With `pat_count` = 0, no shifting or capture takes place, `done` rises 2 cycles after the start edge, and the signature equals `seed_misr`.
- R2: Each load holds `scan_en` high for exactly `shift_len` consecutive cycles. The generator advances once per load shift as a left-shifting Galois register with feedback mask 0x002D (bit 15 out). Chain input i is generator bit (i mod 16) XOR bit ((3i+5) mod 16).
- R3: In shift-launch mode (`mode_loc` = 0), `capture` is high for exactly one cycle, directly after the last shift of each load, and `scan_en` is low in that cycle.
- R4: In double-capture mode (`mode_loc` = 1), the last shift is followed by one cycle with `scan_en` and `capture` both low, then by exactly two consecutive `capture` cycles.
- R5: The signature register folds `scan_out` (chain i into bit i) on every shift cycle, except during the first load. The fold is: shift left, XOR 0x002D if bit 15 was set, then XOR the chain bits. It does not change during captures.
- R6: After the last pattern's capture, one flush load of `shift_len` shifts follows. `done` then rises P*(L+1)+L+2 cycles after the start edge in shift-launch mode, and P*(L+3)+L+2 cycles after it in double-capture mode.
- R7: `pass` is high when the final signature equals `expect_sig`. `done` and `pass` hold until the next start, and later changes to `expect_sig` have no effect on them.
- R8: Mode, shift length and pattern count are sampled at start. A start pulse, or changes to these inputs, during a run have no effect on that run.
- R9: After reset, `scan_en`, `capture`, `done` and `pass` are low. `scan_en` and `capture` are never high together.
- R10: The pattern count is a 17-bit field, so counts above 65535 are run in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and at-speed clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a test run |
| mode_loc | input | 1 | 0 = shift-launch timing, 1 = double-capture timing |
| shift_len | input | 8 | Shift cycles per load (length of the longest chain, at least 1) |
| pat_count | input | 17 | Number of patterns to apply |
| seed_prpg | input | 16 | Generator seed, must be nonzero |
| seed_misr | input | 16 | Signature register start value |
| expect_sig | input | 16 | Expected final signature |
| scan_out | input | 8 | Serial outputs of the scan chains |
| scan_en | output | 1 | Scan-enable to all chains |
| capture | output | 1 | Functional capture pulse enable |
| scan_in | output | 8 | Serial inputs of the scan chains |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Final signature matched, valid with done |

## Verification
Runs are made in both timings, with one-bit, mid-length and full-length chains and with several pattern counts. A bench model of the chains computes the expected signature, so a wrong generator tap, a wrong phase-shift term, a missed or extra fold, or a wrong number of captures each shows up as a mismatch. Runs with a deliberately wrong expected value separate a stuck pass from a real compare. The cycle count to done, the length of each scan-enable burst and the placement of the capture pulses tell the two timings apart and catch an off-by-one in the load, flush or pattern count. A count above 65535 exposes a counter that is too narrow.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_GAP,
    ST_CAP1,
    ST_CAP2,
    ST_FLUSH,
    ST_CMP,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
  parameter int W = 16,
  parameter int NCH = 8,
  parameter logic [W-1:0] POLY = 16'h002D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           seed_ld,
  input  logic [W-1:0]   seed,
  input  logic           step,
  output logic [NCH-1:0] chain_in
);
  logic [W-1:0] lfsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr <= W'(1);
    else if (seed_ld) lfsr <= seed;
    else if (step)    lfsr <= {lfsr[W-2:0], 1'b0} ^ (lfsr[W-1] ? POLY : '0);
  end

  // phase shifter: two generator taps per chain
  for (genvar i = 0; i < NCH; i++) begin : g_phase
    localparam int TA = i % W;
    localparam int TB = (3 * i + 5) % W;
    assign chain_in[i] = lfsr[TA] ^ lfsr[TB];
  end

  // R2
  prpg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_ld && !step) |=> $stable(lfsr));
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int W = 16,
  parameter int NCH = 8,
  parameter logic [W-1:0] POLY = 16'h002D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           seed_ld,
  input  logic [W-1:0]   seed,
  input  logic           fold,
  input  logic [NCH-1:0] din,
  output logic [W-1:0]   sig
);
  logic [W-1:0] din_w;

  always_comb begin
    din_w = '0;
    din_w[NCH-1:0] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sig <= '0;
    else if (seed_ld) sig <= seed;
    else if (fold)    sig <= ({sig[W-2:0], 1'b0} ^ (sig[W-1] ? POLY : '0)) ^ din_w;
  end

  // R5
  misr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_ld && !fold) |=> $stable(sig));
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_loc,
  input  logic [LEN_W-1:0] shift_len,
  input  logic [CNT_W-1:0] pat_count,
  output logic             seed_ld,
  output logic             prpg_step,
  output logic             misr_fold,
  output logic             scan_en,
  output logic             capture,
  output logic             cmp_now,
  output logic             done
);
  seq_state_t       st;
  logic [LEN_W-1:0] shcnt, len_q;
  logic [CNT_W-1:0] patcnt, cnt_q;
  logic             mode_q;
  logic             can_go, last_sh, last_pat;

  assign can_go   = (st == ST_IDLE) || (st == ST_FIN);
  assign seed_ld  = start && can_go;
  assign last_sh  = (shcnt == len_q - LEN_W'(1));
  assign last_pat = (patcnt == cnt_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      shcnt  <= '0;
      patcnt <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (seed_ld) begin
      mode_q <= mode_loc;
      len_q  <= shift_len;
      cnt_q  <= pat_count;
      shcnt  <= '0;
      patcnt <= '0;
      st     <= (pat_count == '0) ? ST_CMP : ST_LOAD;
    end else begin
      case (st)
        ST_LOAD: begin
          if (last_sh) begin
            shcnt <= '0;
            st    <= mode_q ? ST_GAP : ST_CAP1;
          end else begin
            shcnt <= shcnt + LEN_W'(1);
          end
        end
        ST_GAP: st <= ST_CAP1;
        ST_CAP1: begin
          if (mode_q) begin
            st <= ST_CAP2;
          end else begin
            patcnt <= patcnt + CNT_W'(1);
            st     <= last_pat ? ST_FLUSH : ST_LOAD;
          end
        end
        ST_CAP2: begin
          patcnt <= patcnt + CNT_W'(1);
          st     <= last_pat ? ST_FLUSH : ST_LOAD;
        end
        ST_FLUSH: begin
          if (last_sh) begin
            shcnt <= '0;
            st    <= ST_CMP;
          end else begin
            shcnt <= shcnt + LEN_W'(1);
          end
        end
        ST_CMP:  st <= ST_FIN;
        default: st <= st;
      endcase
    end
  end

  assign scan_en   = (st == ST_LOAD) || (st == ST_FLUSH);
  assign capture   = (st == ST_CAP1) || (st == ST_CAP2);
  assign prpg_step = (st == ST_LOAD);
  assign misr_fold = ((st == ST_LOAD) && (patcnt != '0)) || (st == ST_FLUSH);
  assign cmp_now   = (st == ST_CMP);
  assign done      = (st == ST_FIN);

  // R9
  se_cap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en && capture));
  // R3
  los_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !mode_q) |-> $past(scan_en));
  // R4
  loc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAP1 && mode_q) |-> (!$past(scan_en) && !$past(capture)));
  // R4
  loc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAP1 && mode_q) |=> capture);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl #(
  parameter int W = 16,
  parameter int NCH = 8,
  parameter int LEN_W = 8,
  parameter int CNT_W = 17,
  parameter logic [W-1:0] POLY = 16'h002D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_loc,
  input  logic [LEN_W-1:0] shift_len,
  input  logic [CNT_W-1:0] pat_count,
  input  logic [W-1:0]     seed_prpg,
  input  logic [W-1:0]     seed_misr,
  input  logic [W-1:0]     expect_sig,
  input  logic [NCH-1:0]   scan_out,
  output logic             scan_en,
  output logic             capture,
  output logic [NCH-1:0]   scan_in,
  output logic             done,
  output logic             pass
);
  logic         seed_ld, prpg_step, misr_fold, cmp_now;
  logic [W-1:0] sig;

  lbist_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_loc(mode_loc),
    .shift_len(shift_len), .pat_count(pat_count),
    .seed_ld(seed_ld), .prpg_step(prpg_step), .misr_fold(misr_fold),
    .scan_en(scan_en), .capture(capture), .cmp_now(cmp_now), .done(done)
  );

  lbist_prpg #(.W(W), .NCH(NCH), .POLY(POLY)) u_prpg (
    .clk(clk), .rst_n(rst_n), .seed_ld(seed_ld), .seed(seed_prpg),
    .step(prpg_step), .chain_in(scan_in)
  );

  lbist_misr #(.W(W), .NCH(NCH), .POLY(POLY)) u_misr (
    .clk(clk), .rst_n(rst_n), .seed_ld(seed_ld), .seed(seed_misr),
    .fold(misr_fold), .din(scan_out), .sig(sig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pass <= 1'b0;
    else if (seed_ld) pass <= 1'b0;
    else if (cmp_now) pass <= (sig == expect_sig);
  end

  // R7
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(pass));
  // R7
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
endmodule

// File: tb/sim_lbist_ctrl.sv
module sim_lbist_ctrl;
  localparam int N = 8;
  localparam int W = 16;
  localparam int MAXL = 16;
  localparam logic [15:0] POLY = 16'h002D;

  typedef struct packed {
    logic        loc;
    logic [7:0]  len;
    logic [16:0] cnt;
    logic        good;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd4,  17'd3, 1'b1},
    '{1'b1, 8'd4,  17'd3, 1'b1},
    '{1'b0, 8'd1,  17'd5, 1'b1},
    '{1'b1, 8'd16, 17'd2, 1'b1},
    '{1'b0, 8'd7,  17'd6, 1'b0},
    '{1'b1, 8'd3,  17'd1, 1'b0}
  };

  logic clk = 0, rst_n = 0, start = 0, mode_loc = 0;
  logic [7:0] shift_len = 8'd4;
  logic [16:0] pat_count = '0;
  logic [15:0] seed_prpg = 16'hACE1, seed_misr = 16'h1234, expect_sig = '0;
  logic [N-1:0] scan_out, scan_in;
  logic scan_en, capture, done, pass;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  lbist_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_loc(mode_loc),
    .shift_len(shift_len), .pat_count(pat_count), .seed_prpg(seed_prpg),
    .seed_misr(seed_misr), .expect_sig(expect_sig), .scan_out(scan_out),
    .scan_en(scan_en), .capture(capture), .scan_in(scan_in),
    .done(done), .pass(pass)
  );

  function automatic logic [MAXL-1:0] lmask(int len);
    return (MAXL'(1) << len) - MAXL'(1);
  endfunction

  function automatic logic [15:0] lfsr_nx(logic [15:0] l);
    return {l[14:0], 1'b0} ^ (l[15] ? POLY : 16'h0);
  endfunction

  function automatic logic [15:0] misr_nx(logic [15:0] m, logic [N-1:0] d);
    return lfsr_nx(m) ^ {8'h00, d};
  endfunction

  function automatic logic [N-1:0] phase(logic [15:0] l);
    logic [N-1:0] o;
    for (int i = 0; i < N; i++) o[i] = l[i % W] ^ l[(3 * i + 5) % W];
    return o;
  endfunction

  function automatic logic [N*MAXL-1:0] shiftc(logic [N*MAXL-1:0] s, logic [N-1:0] din, int len);
    logic [N*MAXL-1:0] r;
    for (int i = 0; i < N; i++)
      r[i*MAXL +: MAXL] = ((s[i*MAXL +: MAXL] << 1) | MAXL'(din[i])) & lmask(len);
    return r;
  endfunction

  function automatic logic [N-1:0] outs(logic [N*MAXL-1:0] s, int len);
    logic [N-1:0] o;
    for (int i = 0; i < N; i++) o[i] = s[i*MAXL + len - 1];
    return o;
  endfunction

  // functional logic seen between scan chains during capture
  function automatic logic [N*MAXL-1:0] capf(logic [N*MAXL-1:0] s, int len);
    logic [N*MAXL-1:0] r;
    logic [MAXL-1:0] a, b, d;
    for (int i = 0; i < N; i++) begin
      a = s[i*MAXL +: MAXL];
      b = s[((i+1)%N)*MAXL +: MAXL];
      d = s[((i+2)%N)*MAXL +: MAXL];
      r[i*MAXL +: MAXL] = (a ^ ((b << 1) | (b >> (len - 1))) ^ (a & d) ^ MAXL'(i + 1)) & lmask(len);
    end
    return r;
  endfunction

  function automatic logic [15:0] golden(logic loc, int len, int cnt, logic [15:0] sp, logic [15:0] sm);
    logic [15:0] l = sp, m = sm;
    logic [N*MAXL-1:0] s = '0;
    for (int p = 0; p < cnt; p++) begin
      for (int k = 0; k < len; k++) begin
        if (p > 0) m = misr_nx(m, outs(s, len));
        s = shiftc(s, phase(l), len);
        l = lfsr_nx(l);
      end
      s = capf(s, len);
      if (loc) s = capf(s, len);
    end
    if (cnt > 0)
      for (int k = 0; k < len; k++) begin
        m = misr_nx(m, outs(s, len));
        s = shiftc(s, '0, len);
      end
    return m;
  endfunction

  // scan chain model
  logic [N*MAXL-1:0] ch = '0;
  int cur_len = 4;
  logic cur_loc = 0;
  assign scan_out = outs(ch, cur_len);
  always @(posedge clk) begin
    if (scan_en) ch <= shiftc(ch, scan_in, cur_len);
    else if (capture) ch <= capf(ch, cur_len);
  end

  // protocol monitor
  int viol = 0, caps = 0, run = 0;
  logic p_se = 0, p_cap = 0, p2_se = 0, p2_cap = 0;
  always @(negedge clk) begin
    if (scan_en && capture) viol++;
    if (scan_en) run++;
    else if (p_se) begin
      if (run != cur_len) viol++;
      run = 0;
    end
    if (capture) begin
      caps++;
      if (!cur_loc) begin
        if (!p_se || p_cap) viol++;
      end else if (!p_cap) begin
        if (p_se || !p2_se) viol++;
      end else if (p2_cap) viol++;
    end
    p2_se = p_se; p2_cap = p_cap; p_se = scan_en; p_cap = capture;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_lat(logic loc, int len, int cnt);
    if (cnt == 0) return 2;
    return cnt * (len + (loc ? 3 : 1)) + len + 2;
  endfunction

  // inj: pulse start and disturb settings mid-run
  task automatic do_run(logic loc, int len, int cnt, logic [15:0] expv, bit inj, output int lat);
    @(negedge clk);
    mode_loc = loc; shift_len = 8'(len); pat_count = 17'(cnt); expect_sig = expv;
    cur_len = len; cur_loc = loc;
    viol = 0; caps = 0; run = 0;
    start = 1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 0;
    while (!done && lat < 200000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (inj && lat == 5) begin
        start = 1; mode_loc = ~loc; shift_len = 8'(len + 2); pat_count = 17'(cnt + 3);
      end else if (inj && lat == 6) start = 0;
    end
  endtask

  initial begin
    int lat;
    logic [15:0] g;
    #1;
    // R9 reset state
    chk(!scan_en && !capture, "R9", "scan_en/capture after reset", {scan_en, capture}, 0);
    chk(!done && !pass, "R9", "done/pass after reset", {done, pass}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!scan_en && !capture && !done, "R9", "idle outputs", {scan_en, capture, done}, 0);

    for (int v = 0; v < NV; v++) begin
      g = golden(VECS[v].loc, int'(VECS[v].len), int'(VECS[v].cnt), seed_prpg, seed_misr);
      do_run(VECS[v].loc, int'(VECS[v].len), int'(VECS[v].cnt),
             VECS[v].good ? g : g ^ 16'h0001, 1'b0, lat);
      chk(lat == exp_lat(VECS[v].loc, int'(VECS[v].len), int'(VECS[v].cnt)), "R6",
          "cycles to done", lat, exp_lat(VECS[v].loc, int'(VECS[v].len), int'(VECS[v].cnt)));
      chk(pass == VECS[v].good, "R5", "pass vs bench signature (R2 stimulus)", pass, VECS[v].good);
      chk(viol == 0, VECS[v].loc ? "R4" : "R3", "timing violations", viol, 0);
      chk(caps == int'(VECS[v].cnt) * (VECS[v].loc ? 2 : 1), VECS[v].loc ? "R4" : "R3",
          "capture pulses", caps, int'(VECS[v].cnt) * (VECS[v].loc ? 2 : 1));
    end

    // R1 zero patterns: signature stays at seed
    do_run(1'b0, 4, 0, seed_misr, 1'b0, lat);
    chk(lat == 2, "R1", "cycles to done, zero patterns", lat, 2);
    chk(pass == 1'b1, "R1", "signature equals seed", pass, 1);
    chk(caps == 0 && viol == 0, "R1", "no capture with zero patterns", caps, 0);

    // R7 hold after done, expect change ignored
    expect_sig = ~expect_sig;
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R7", "done held", done, 1);
    chk(pass == 1'b1, "R7", "pass held after expect change", pass, 1);

    // R8 start and settings ignored mid-run
    g = golden(1'b0, 5, 4, seed_prpg, seed_misr);
    do_run(1'b0, 5, 4, g, 1'b1, lat);
    chk(lat == exp_lat(1'b0, 5, 4), "R8", "cycles to done with mid-run start", lat, exp_lat(1'b0, 5, 4));
    chk(pass == 1'b1, "R8", "signature with mid-run changes", pass, 1);

    // R10 count above 16 bits
    g = golden(1'b0, 1, 65538, seed_prpg, seed_misr);
    do_run(1'b0, 1, 65538, g, 1'b0, lat);
    chk(lat == exp_lat(1'b0, 1, 65538), "R10", "cycles to done, large count", lat, exp_lat(1'b0, 1, 65538));
    chk(pass == 1'b1, "R10", "signature, large count", pass, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 195000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule